// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block is the processor side of a bank of three down-counting timer channels. A host drives an 8-bit data bus, a 2-bit register address, a chip select and separate write and read strobes. Addresses 0 to 2 reach the channel count registers and address 3 reaches the shared control register. The block turns control words into per-channel mode and access settings, assembles 16-bit counts from byte writes, and lets the host freeze and read back a channel's running count.

The counting logic sits outside this block. It takes each channel's new count, a one-cycle strobe that says the count is complete, and the 3-bit mode field. It returns its live count, which this block can capture or pass straight through on reads. All writes take effect on the rising clock edge. Read data is combinational from the address and the current state, and a read strobe advances the byte sequence at the clock edge.

Top module: `tmr_bus_regif`

## Requirements
- R1: With chip select and write high, addresses 0, 1 and 2 write channels 0, 1 and 2, and address 3 writes a control word. In the control word, bits 7:6 select the channel (3 selects none), bits 5:4 select the access code, bits 3:1 select the mode and bit 0 is ignored. The mode appears on `ch_mode[3*i+2:3*i]` from the next cycle.
- R2: With access code 11, the first data write to a channel holds the low byte and the second write supplies the high byte. Only after the second write does `cnt_val` show `{high,low}` and `cnt_load` pulse for one cycle; the first write leaves both unchanged.
- R3: Access code 01 loads `{00h,data}` and access code 10 loads `{data,00h}`. Each is loaded on a single write, with a load pulse.
- R4: Access code 00 is a latch command. It captures the selected channel's `live_cnt` at that edge, and later changes of `live_cnt` do not alter the captured value.
- R5: While a latch is held, the first read of the channel address returns the captured low byte and the second returns the captured high byte. The latch is then released.
- R6: A latch command to a channel that already holds a latch is ignored. The first captured value is the one read back.
- R7: A control word with a nonzero access code sets that channel's write and read sequences back to the low byte and drops any held latch.
- R8: With chip select low, write and read strobes have no effect on counts, modes, latches or byte sequences, and `rdata` is 00h.
- R9: A read of address 3 returns 00h.
- R10: Reads without a held latch return `live_cnt` bytes according to the access code: the low byte for 01, the high byte for 10, and low then high on alternate reads for 11.
- R11: After reset every channel has count 0, mode 0 and access code 11, with no latch held and no load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| live_cnt | input | 48 | Running count of each channel, channel i at bits 16*i+15:16*i |
| cnt_val | output | 48 | Programmed count of each channel |
| cnt_load | output | 3 | One-cycle pulse per channel when its count is complete |
| ch_mode | output | 9 | Mode field per channel, 3 bits each |

## Verification
Count writes are tried with each access code. A two-byte sequence is checked against single-byte loads, which tells byte ordering apart from zero filling. Latch tests change `live_cnt` between the capture and the reads, and send a second latch command, to separate a true snapshot from a pass-through. A control word issued between a low-byte write and the rest of the sequence shows whether the pointers were reset. Traffic sent with chip select low, and reads of address 3, show that ignored accesses leave no trace.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tmr_regif_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int BW   = 8
) (
    input  logic          cs,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [BW-1:0] wdata,
    output logic [N_CH-1:0] ctl_we,
    output logic [N_CH-1:0] data_we,
    output logic [N_CH-1:0] rd_adv,
    output acc_e          ctl_acc,
    output logic [2:0]    ctl_mode
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic ctl_hit;
    assign ctl_hit  = cs && wr_en && (addr == CTL_ADDR);
    assign ctl_acc  = acc_e'(wdata[5:4]);
    assign ctl_mode = wdata[3:1];

    for (genvar i = 0; i < N_CH; i++) begin : g_dec
        assign ctl_we[i]  = ctl_hit && (wdata[7:6] == 2'(i));
        assign data_we[i] = cs && wr_en && (addr == 2'(i));
        assign rd_adv[i]  = cs && rd_en && (addr == 2'(i));
    end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regif_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  acc_e          ctl_acc,
    input  logic [2:0]    ctl_mode,
    input  logic          data_we,
    input  logic          rd_adv,
    input  logic [BW-1:0] wdata,
    input  logic [2*BW-1:0] live,
    output logic [2*BW-1:0] cnt,
    output logic          load,
    output logic [2:0]    mode,
    output logic [BW-1:0] rbyte
);
    localparam int CW = 2 * BW;

    typedef struct packed {
        acc_e          acc;
        logic [2:0]    mode;
        logic          wr_hi;
        logic [BW-1:0] lo_buf;
        logic [CW-1:0] cnt;
        logic          load;
        logic          latched;
        logic          rd_hi;
        logic [CW-1:0] snap;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        if (ctl_we) begin
            if (ctl_acc == ACC_LATCH) begin
                if (!st_q.latched) begin
                    st_d.latched = 1'b1;
                    st_d.snap    = live;
                    st_d.rd_hi   = 1'b0;
                end
            end else begin
                st_d.acc     = ctl_acc;
                st_d.mode    = ctl_mode;
                st_d.wr_hi   = 1'b0;
                st_d.latched = 1'b0;
                st_d.rd_hi   = 1'b0;
            end
        end else begin
            if (data_we) begin
                unique case (st_q.acc)
                    ACC_LO: begin
                        st_d.cnt  = {{BW{1'b0}}, wdata};
                        st_d.load = 1'b1;
                    end
                    ACC_HI: begin
                        st_d.cnt  = {wdata, {BW{1'b0}}};
                        st_d.load = 1'b1;
                    end
                    ACC_LOHI: begin
                        if (!st_q.wr_hi) begin
                            st_d.lo_buf = wdata;
                            st_d.wr_hi  = 1'b1;
                        end else begin
                            st_d.cnt   = {wdata, st_q.lo_buf};
                            st_d.wr_hi = 1'b0;
                            st_d.load  = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_adv) begin
                if (st_q.latched) begin
                    if (st_q.rd_hi) begin
                        st_d.latched = 1'b0;
                        st_d.rd_hi   = 1'b0;
                    end else begin
                        st_d.rd_hi = 1'b1;
                    end
                end else if (st_q.acc == ACC_LOHI) begin
                    st_d.rd_hi = !st_q.rd_hi;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.acc   <= ACC_LOHI;
        end else begin
            st_q <= st_d;
        end
    end

    logic [CW-1:0] rd_src;
    logic          rd_hi_sel;
    assign rd_src    = st_q.latched ? st_q.snap : live;
    assign rd_hi_sel = st_q.latched ? st_q.rd_hi
                     : ((st_q.acc == ACC_HI) || (st_q.acc == ACC_LOHI && st_q.rd_hi));
    assign rbyte = rd_hi_sel ? rd_src[CW-1:BW] : rd_src[BW-1:0];
    assign cnt   = st_q.cnt;
    assign load  = st_q.load;
    assign mode  = st_q.mode;

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.latched && !rd_adv && !(ctl_we && ctl_acc != ACC_LATCH))
        |=> (st_q.latched && $stable(st_q.snap)));

    assert_pair_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.acc == ACC_LOHI) |-> $past(st_q.wr_hi));

    assert_cfg_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_acc != ACC_LATCH) |=> (!st_q.latched && !st_q.wr_hi && !st_q.rd_hi));

    assert_lo_only_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.load && st_q.acc == ACC_LO) |-> (st_q.cnt[CW-1:BW] == '0));
endmodule

// File: rtl/tmr_bus_regif.sv
module tmr_bus_regif
    import tmr_regif_pkg::*;
#(
    parameter int N_CH = 3,
    parameter int BW   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [1:0]           addr,
    input  logic [BW-1:0]        wdata,
    output logic [BW-1:0]        rdata,
    input  logic [N_CH*2*BW-1:0] live_cnt,
    output logic [N_CH*2*BW-1:0] cnt_val,
    output logic [N_CH-1:0]      cnt_load,
    output logic [N_CH*3-1:0]    ch_mode
);
    localparam int CW = 2 * BW;

    logic [N_CH-1:0] ctl_we, data_we, rd_adv;
    acc_e            ctl_acc;
    logic [2:0]      ctl_mode;
    logic [BW-1:0]   rbyte [N_CH];

    tmr_addr_decode #(.N_CH(N_CH), .BW(BW)) u_dec (
        .cs(cs), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .ctl_we(ctl_we), .data_we(data_we), .rd_adv(rd_adv),
        .ctl_acc(ctl_acc), .ctl_mode(ctl_mode)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tmr_chan_regs #(.BW(BW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctl_we(ctl_we[i]), .ctl_acc(ctl_acc), .ctl_mode(ctl_mode),
            .data_we(data_we[i]), .rd_adv(rd_adv[i]), .wdata(wdata),
            .live(live_cnt[i*CW +: CW]),
            .cnt(cnt_val[i*CW +: CW]), .load(cnt_load[i]),
            .mode(ch_mode[i*3 +: 3]), .rbyte(rbyte[i])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (cs && addr == 2'(i)) rdata = rbyte[i];
        end
    end

    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_we, data_we}));

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(cnt_val) && $stable(ch_mode)));

    assert_ctl_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd_en && addr == 2'd3) |-> (rdata == '0));
endmodule

// File: tb/sim_tmr_bus_regif.sv
module sim_tmr_bus_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [47:0] live = '0;
    wire  [7:0]  rdata;
    wire  [47:0] cnt_val;
    wire  [2:0]  cnt_load;
    wire  [8:0]  ch_mode;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    logic [7:0]  rd_q[$];
    string       rd_tag[$];
    logic [17:0] ld_q[$];
    string       ld_tag[$];

    tmr_bus_regif u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .live_cnt(live),
        .cnt_val(cnt_val), .cnt_load(cnt_load), .ch_mode(ch_mode)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
        @(posedge clk); #2;
        cs = sel; wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_q.push_back(exp); rd_tag.push_back(tag);
        @(posedge clk); #2;
        cs = 1'b1; rd_en = 1'b1; addr = a;
        @(posedge clk); #2;
        cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic exp_load(input int ch, input logic [15:0] v, input string tag);
        ld_q.push_back({2'(ch), v}); ld_tag.push_back(tag);
    endtask

    // monitor: compares design results with the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cs && rd_en) begin
                if (rd_q.size() == 0) begin
                    tests++; fails++;
                    $display("FAIL unexpected read actual=%0h expected=none", rdata);
                end else begin
                    chk(rd_tag.pop_front(), {24'h0, rdata}, {24'h0, rd_q.pop_front()});
                end
            end
            for (int i = 0; i < 3; i++) begin
                if (cnt_load[i]) begin
                    if (ld_q.size() == 0) begin
                        tests++; fails++;
                        $display("FAIL R8 unexpected load ch%0d actual=%0h expected=none",
                                 i, cnt_val[i*16 +: 16]);
                    end else begin
                        logic [17:0] e;
                        e = ld_q.pop_front();
                        chk(ld_tag.pop_front(), {14'h0, 2'(i), cnt_val[i*16 +: 16]}, {14'h0, e});
                    end
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 cnt", cnt_val, 48'h0);
        chk("R11 mode", {23'h0, ch_mode}, 32'h0);
        chk("R11 load", {29'h0, cnt_load}, 32'h0);
        bus_rd(2'd3, 8'h00, "R9 ctl read");

        // R1/R2: channel 2, pair access, mode 0
        bus_wr(2'd3, 8'hB0);
        chk("R1 mode ch2", {29'h0, ch_mode[8:6]}, 32'd0);
        bus_wr(2'd2, 8'h34);
        chk("R2 after low byte", {16'h0, cnt_val[47:32]}, 32'h0);
        exp_load(2, 16'h1234, "R2 pair ch2");
        bus_wr(2'd2, 8'h12);

        // R1/R2: channel 1, pair access, mode 3
        bus_wr(2'd3, 8'h76);
        chk("R1 mode ch1", {29'h0, ch_mode[5:3]}, 32'd3);
        exp_load(1, 16'h07D0, "R2 pair ch1");
        bus_wr(2'd1, 8'hD0);
        bus_wr(2'd1, 8'h07);

        // R3: single-byte codes on channel 0
        bus_wr(2'd3, 8'h15);
        chk("R1 mode ch0 bit0 ignored", {29'h0, ch_mode[2:0]}, 32'd2);
        exp_load(0, 16'h00AB, "R3 low only");
        bus_wr(2'd0, 8'hAB);
        bus_wr(2'd3, 8'h28);
        chk("R1 mode ch0", {29'h0, ch_mode[2:0]}, 32'd4);
        exp_load(0, 16'h5C00, "R3 high only");
        bus_wr(2'd0, 8'h5C);

        // R10: unlatched read, high-only code
        live[15:0] = 16'h7A3C;
        bus_rd(2'd0, 8'h7A, "R10 high only read");

        // R4/R5/R6: latch channel 1
        live[31:16] = 16'hBEEF;
        bus_wr(2'd3, 8'h40);
        live[31:16] = 16'h2211;
        bus_wr(2'd3, 8'h40);
        bus_rd(2'd1, 8'hEF, "R5 latched low");
        bus_rd(2'd1, 8'hBE, "R6 latched high");
        bus_rd(2'd1, 8'h11, "R10 live low");
        bus_rd(2'd1, 8'h22, "R10 live high");

        // R7: control word clears latch and byte pointers
        live[47:32] = 16'hCAFE;
        bus_wr(2'd3, 8'h80);
        live[47:32] = 16'h0102;
        bus_rd(2'd2, 8'hFE, "R4 latched low");
        bus_wr(2'd2, 8'h78);
        bus_wr(2'd3, 8'hB0);
        exp_load(2, 16'hBC9A, "R7 pointer reset");
        bus_wr(2'd2, 8'h9A);
        bus_wr(2'd2, 8'hBC);
        bus_rd(2'd2, 8'h02, "R7 latch dropped low");
        bus_rd(2'd2, 8'h01, "R7 latch dropped high");

        // R8: chip select low
        bus_wr(2'd3, 8'h5A, 1'b0);
        chk("R8 mode kept", {29'h0, ch_mode[5:3]}, 32'd3);
        bus_wr(2'd1, 8'h55, 1'b0);
        bus_wr(2'd1, 8'h66, 1'b0);
        chk("R8 count kept", {16'h0, cnt_val[31:16]}, 32'h07D0);
        @(posedge clk); #2 rd_en = 1'b1; addr = 2'd1;
        @(negedge clk);
        chk("R8 rdata idle", {24'h0, rdata}, 32'h0);
        @(posedge clk); #2 rd_en = 1'b0;
        bus_rd(2'd1, 8'h11, "R8 read pointer kept");
        bus_rd(2'd3, 8'h00, "R9 ctl read again");

        repeat (4) @(posedge clk);
        chk("R2 pending loads", ld_q.size(), 0);
        chk("R5 pending reads", rd_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule